// File: doc/BRIEF.md
# Staged Cluster Clock-Enable Controller

This block drives the clock-enable inputs of the integrated clock-gate cells that feed a clustered, statically scheduled datapath. Each cluster has four pipeline stages (decode, register read, execute, writeback), and each pair of cluster and stage gets its own enable. Fetch places a shutoff mask on a bus and raises a one-cycle strobe. The mask is captured only while the strobe is high. A set bit turns a cluster off and a clear bit turns it back on.

The enable of a new mask does not reach all stages at once. The decode-stage enable takes the new value on the same clock edge that accepts the mask. Each later stage copies the stage before it one edge later. Bundles that are already past decode therefore still find their clocks running, and the pipeline drains without a stall.

Cluster 0 carries the control flow and its clocks never stop. A global override input forces every enable high for as long as it is held. The underlying cascade keeps running while the override is active, so releasing the override exposes the state that would have been present without it.

Top module: `cg_cluster_clock_ctrl`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, every enable of every stage and cluster is 1.
- R2: A mask presented while `mask_stb` is 0 has no effect: no enable of any stage changes because of it.
- R3: On the clock edge where `mask_stb` is 1 (with `force_all_on` at 0), `en_dec[c]` becomes the inverse of `mask_off[c]` for every cluster c other than 0. Bit value 1 in `mask_off` means the cluster is off.
- R4: The register-read, execute and writeback enables each take the value the previous stage held one cycle earlier, so a mask reaches writeback three edges after decode. Back-to-back masks appear as a staircase across the stages.
- R5: Bit 0 of every stage enable is always 1, whatever the mask holds.
- R6: A later accepted mask with clear bits turns those clusters back on through the same decode-first cascade.
- R7: One edge after `force_all_on` is sampled at 1, every enable of every stage is 1. Once it is released, the enables return on the next edge to the cascaded state.
- R8: A mask accepted while the override is active is stored and cascaded without showing at the outputs. After the override is released, all stages show that mask if at least three edges have passed since it was accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mask_stb | input | 1 | Strobe from fetch; the mask is captured only while this is 1 |
| mask_off | input | NUM_CLUSTERS | Shutoff mask, 1 = cluster off, 0 = cluster on |
| force_all_on | input | 1 | Override; forces all enables to 1 |
| en_dec | output | NUM_CLUSTERS | Decode-stage clock enables, one per cluster |
| en_rr | output | NUM_CLUSTERS | Register-read-stage clock enables |
| en_ex | output | NUM_CLUSTERS | Execute-stage clock enables |
| en_wb | output | NUM_CLUSTERS | Writeback-stage clock enables |

## Verification
Two functions can meet on the same edge: mask capture and the override. The bench raises the strobe with a new mask on the same edge as `force_all_on`. It then checks that every enable reads 1 for as long as the override is held. After release, every stage must show the mask captured during the override, not the older mask, and this proves the capture was not lost. A second collision comes from strobing two different masks on consecutive edges. The bench judges this by the staircase pattern expected across the four stages on each of the following edges.

// File: rtl/cg_clk_pkg.sv
package cg_clk_pkg;
  // Pipeline depth of every cluster: decode, register read, execute, writeback.
  localparam int STAGE_CNT = 4;
  localparam int MAX_CLUSTERS = 4;

  typedef enum logic [1:0] {
    STG_DEC = 2'd0,
    STG_RR  = 2'd1,
    STG_EX  = 2'd2,
    STG_WB  = 2'd3
  } stage_e;
endpackage

// File: rtl/cg_mask_latch.sv
// Holds the shutoff mask. Captures only under the strobe; the lowest
// cluster bit is never stored as "off".
module cg_mask_latch #(
  parameter int NUM_CLUSTERS = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    mask_stb,
  input  logic [NUM_CLUSTERS-1:0] mask_off,
  output logic [NUM_CLUSTERS-1:0] hold_nxt
);
  localparam logic [NUM_CLUSTERS-1:0] KEEP_MASK = ~{{(NUM_CLUSTERS-1){1'b0}}, 1'b1};

  logic [NUM_CLUSTERS-1:0] hold_q;

  always_comb begin
    hold_nxt = hold_q;
    if (mask_stb) hold_nxt = mask_off & KEEP_MASK;
  end

  always_ff @(posedge clk) begin
    if (rst) hold_q <= '0;
    else     hold_q <= hold_nxt;
  end

  // R2: without the strobe the stored mask does not move
  p_hold_without_stb_r2: assert property (@(posedge clk) disable iff (rst)
    !mask_stb |=> $stable(hold_q));

  // R5: lowest cluster never recorded as off
  p_cluster0_not_held_r5: assert property (@(posedge clk) disable iff (rst)
    !hold_q[0]);
endmodule

// File: rtl/cg_gate_decide.sv
// Turns the stored shutoff mask into a per-cluster run decision.
module cg_gate_decide #(
  parameter int NUM_CLUSTERS = 4
) (
  input  logic [NUM_CLUSTERS-1:0] hold_nxt,
  output logic [NUM_CLUSTERS-1:0] run_nxt
);
  always_comb begin
    for (int c = 0; c < NUM_CLUSTERS; c++) begin
      run_nxt[c] = (c == 0) ? 1'b1 : ~hold_nxt[c];
    end
  end
endmodule

// File: rtl/cg_stage_cascade.sv
// Ripples the run decision through the pipeline stages, one edge per stage,
// and applies the override on the registered enables.
module cg_stage_cascade
  import cg_clk_pkg::*;
#(
  parameter int NUM_CLUSTERS = 4
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   force_all_on,
  input  logic [NUM_CLUSTERS-1:0]                run_in,
  output logic [STAGE_CNT-1:0][NUM_CLUSTERS-1:0] en_q
);
  logic [STAGE_CNT-1:0][NUM_CLUSTERS-1:0] run_q;
  logic [STAGE_CNT-1:0][NUM_CLUSTERS-1:0] run_d;

  genvar s;
  generate
    for (s = 0; s < STAGE_CNT; s++) begin : g_stage
      if (s == 0) begin : g_head
        assign run_d[s] = run_in;
      end else begin : g_tail
        assign run_d[s] = run_q[s-1];

        // R4: each later stage copies the earlier one a cycle late
        p_stage_shift_r4: assert property (@(posedge clk) disable iff (rst)
          1'b1 |=> run_q[s] == $past(run_q[s-1]));
      end

      always_ff @(posedge clk) begin
        if (rst) begin
          run_q[s] <= '1;
          en_q[s]  <= '1;
        end else begin
          run_q[s] <= run_d[s];
          en_q[s]  <= run_d[s] | {NUM_CLUSTERS{force_all_on}};
        end
      end

      // R7: override gives all-on enables one edge later
      p_force_on_r7: assert property (@(posedge clk) disable iff (rst)
        force_all_on |=> &en_q[s]);
    end
  endgenerate
endmodule

// File: rtl/cg_cluster_clock_ctrl.sv
module cg_cluster_clock_ctrl
  import cg_clk_pkg::*;
#(
  parameter int NUM_CLUSTERS = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    mask_stb,
  input  logic [NUM_CLUSTERS-1:0] mask_off,
  input  logic                    force_all_on,
  output logic [NUM_CLUSTERS-1:0] en_dec,
  output logic [NUM_CLUSTERS-1:0] en_rr,
  output logic [NUM_CLUSTERS-1:0] en_ex,
  output logic [NUM_CLUSTERS-1:0] en_wb
);
  localparam logic [NUM_CLUSTERS-1:0] LSB_ONE = {{(NUM_CLUSTERS-1){1'b0}}, 1'b1};

  initial begin
    if (NUM_CLUSTERS < 2 || NUM_CLUSTERS > MAX_CLUSTERS)
      $error("NUM_CLUSTERS out of range");
  end

  logic [NUM_CLUSTERS-1:0]                hold_nxt;
  logic [NUM_CLUSTERS-1:0]                run_nxt;
  logic [STAGE_CNT-1:0][NUM_CLUSTERS-1:0] en_q;

  cg_mask_latch #(.NUM_CLUSTERS(NUM_CLUSTERS)) u_latch (
    .clk      (clk),
    .rst      (rst),
    .mask_stb (mask_stb),
    .mask_off (mask_off),
    .hold_nxt (hold_nxt)
  );

  cg_gate_decide #(.NUM_CLUSTERS(NUM_CLUSTERS)) u_decide (
    .hold_nxt (hold_nxt),
    .run_nxt  (run_nxt)
  );

  cg_stage_cascade #(.NUM_CLUSTERS(NUM_CLUSTERS)) u_cascade (
    .clk          (clk),
    .rst          (rst),
    .force_all_on (force_all_on),
    .run_in       (run_nxt),
    .en_q         (en_q)
  );

  assign en_dec = en_q[STG_DEC];
  assign en_rr  = en_q[STG_RR];
  assign en_ex  = en_q[STG_EX];
  assign en_wb  = en_q[STG_WB];

  // R3: accepted mask lands on decode at the capturing edge
  p_dec_takes_mask_r3: assert property (@(posedge clk) disable iff (rst)
    (mask_stb && !force_all_on) |=> en_dec == ($past(~mask_off) | LSB_ONE));

  // R5: cluster 0 clocks always run
  p_cluster0_runs_r5: assert property (@(posedge clk) disable iff (rst)
    en_dec[0] && en_rr[0] && en_ex[0] && en_wb[0]);

  // R1: first cycle after reset everything is enabled
  p_reset_all_on_r1: assert property (@(posedge clk)
    rst |=> (&en_dec && &en_rr && &en_ex && &en_wb));
endmodule

// File: tb/cg_cluster_clock_ctrl_tb.sv
module cg_cluster_clock_ctrl_tb_top;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst;
  logic         mask_stb;
  logic [N-1:0] mask_off;
  logic         force_all_on;
  logic [N-1:0] en_dec, en_rr, en_ex, en_wb;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  cg_cluster_clock_ctrl #(.NUM_CLUSTERS(N)) dut_i (
    .clk          (clk),
    .rst          (rst),
    .mask_stb     (mask_stb),
    .mask_off     (mask_off),
    .force_all_on (force_all_on),
    .en_dec       (en_dec),
    .en_rr        (en_rr),
    .en_ex        (en_ex),
    .en_wb        (en_wb)
  );

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic chk_all(input string tag, input logic [N-1:0] d, input logic [N-1:0] r,
                         input logic [N-1:0] e, input logic [N-1:0] w);
    chk({tag, " dec"}, en_dec, d);
    chk({tag, " rr"},  en_rr,  r);
    chk({tag, " ex"},  en_ex,  e);
    chk({tag, " wb"},  en_wb,  w);
  endtask

  // Inputs change on the falling edge; after one rising edge, sample on the next falling edge.
  task automatic tick();
    @(negedge clk);
  endtask

  task automatic strobe(input logic [N-1:0] m);
    mask_off = m;
    mask_stb = 1'b1;
    tick();
    mask_stb = 1'b0;
  endtask

  task automatic t_reset_r1();
    rst = 1'b1; mask_stb = 1'b0; mask_off = '0; force_all_on = 1'b0;
    tick(); tick();
    chk_all("R1 during reset", 4'hF, 4'hF, 4'hF, 4'hF);
    rst = 1'b0;
    tick();
    chk_all("R1 after reset", 4'hF, 4'hF, 4'hF, 4'hF);
  endtask

  task automatic t_no_strobe_r2();
    mask_off = 4'b1110;
    for (int i = 0; i < 4; i++) begin
      tick();
      chk_all("R2 mask without strobe", 4'hF, 4'hF, 4'hF, 4'hF);
    end
    mask_off = '0;
  endtask

  task automatic t_shutoff_r3_r4();
    strobe(4'b1010);
    chk_all("R3 decode same edge", 4'b0101, 4'hF, 4'hF, 4'hF);
    mask_off = 4'b1111;  // strobe low: ignored (R2)
    tick();
    chk_all("R4 rr one later", 4'b0101, 4'b0101, 4'hF, 4'hF);
    tick();
    chk_all("R4 ex two later", 4'b0101, 4'b0101, 4'b0101, 4'hF);
    tick();
    chk_all("R4 wb three later", 4'b0101, 4'b0101, 4'b0101, 4'b0101);
  endtask

  task automatic t_cluster0_r5();
    strobe(4'b1111);
    chk_all("R5 all off requested", 4'b0001, 4'b0101, 4'b0101, 4'b0101);
    for (int i = 0; i < 3; i++) tick();
    chk_all("R5 cluster0 stays on", 4'b0001, 4'b0001, 4'b0001, 4'b0001);
  endtask

  task automatic t_turn_on_r6();
    strobe(4'b0000);
    chk_all("R6 decode back on", 4'hF, 4'b0001, 4'b0001, 4'b0001);
    tick();
    chk_all("R6 rr back on", 4'hF, 4'hF, 4'b0001, 4'b0001);
    tick(); tick();
    chk_all("R6 all back on", 4'hF, 4'hF, 4'hF, 4'hF);
  endtask

  task automatic t_staircase_r4();
    mask_off = 4'b0010; mask_stb = 1'b1;
    tick();
    mask_off = 4'b1100;
    tick();
    mask_stb = 1'b0;
    chk_all("R4 staircase edge2", 4'b0011, 4'b1101, 4'hF, 4'hF);
    tick();
    chk_all("R4 staircase edge3", 4'b0011, 4'b0011, 4'b1101, 4'hF);
    tick();
    chk_all("R4 staircase edge4", 4'b0011, 4'b0011, 4'b0011, 4'b1101);
    tick();
    chk_all("R4 staircase settled", 4'b0011, 4'b0011, 4'b0011, 4'b0011);
  endtask

  task automatic t_override_r7_r8();
    force_all_on = 1'b1;
    strobe(4'b0110);
    chk_all("R7 override with strobe", 4'hF, 4'hF, 4'hF, 4'hF);
    for (int i = 0; i < 4; i++) begin
      tick();
      chk_all("R7 override held", 4'hF, 4'hF, 4'hF, 4'hF);
    end
    force_all_on = 1'b0;
    tick();
    chk_all("R8 mask from override shows", 4'b1001, 4'b1001, 4'b1001, 4'b1001);
    // Short override: released before the cascade moves on
    force_all_on = 1'b1;
    tick();
    chk_all("R7 short override", 4'hF, 4'hF, 4'hF, 4'hF);
    force_all_on = 1'b0;
    tick();
    chk_all("R7 release restores", 4'b1001, 4'b1001, 4'b1001, 4'b1001);
  endtask

  initial begin
    t_reset_r1();
    t_no_strobe_r2();
    t_shutoff_r3_r4();
    t_cluster0_r5();
    t_turn_on_r6();
    t_staircase_r4();
    t_override_r7_r8();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule